// File: doc/BRIEF.md
# Bus Release Handshake Controller

This block sits on the master side of a CPU bus interface and decides when the CPU gives the bus to an external master. External masters, such as a DMA engine, pull one shared active-low request line. Several of them may drive it together as a wired-OR. The line arrives with no timing relation to the bus clock, so the block first passes it through a flop chain before any logic uses it. Priority among the requesters is settled outside the block.

The CPU core reports each bus transaction with a one-cycle start pulse and a one-cycle done pulse. The block looks at the synchronised request only on a start pulse. If the request is active there, the bus is handed over once that transaction completes. On handover the block drives an active-low acknowledge and raises a disconnect flag. It also raises a stall toward the core so that the core begins no new transaction. It drops the output enables of the control-signal group so that those pins float. The acknowledge and the two status lines are outside that group and stay driven.

A lock flag, set and cleared by program-controlled strobes, keeps the CPU on the bus while it is set. A request that is refused because of the lock is looked at again on the first transaction start after the lock clears. The CPU takes the bus back once the external request goes away.

Top module: `busrel_top`

## Requirements
- R1: After synchronous reset, `back_n` is 1, `disc` is 0, `stall` is 0 and every bit of `ctrl_oe` is 1.
- R2: `breq_n` passes through two flops before use. A request that goes low on the same cycle that `txn_start` is sampled is not yet seen, so it does not cause a grant at the end of that transaction.
- R3: The request is looked at only in the cycle where `txn_start` is 1. A request that appears after the start of a transaction does not grant the bus at the end of that transaction. It is honoured at the next transaction start.
- R4: When a request has been seen at a transaction start, `back_n` stays 1 until `txn_done`. It goes to 0 on the clock edge that samples `txn_done` = 1.
- R5: While `back_n` is 0, `disc` is 1, `stall` is 1 and every bit of `ctrl_oe` is 0 (control group floating). While `back_n` is 1, every bit of `ctrl_oe` is 1.
- R6: A `lock_set` strobe sets the lock, and while the lock is set no grant occurs, even when a request is present at a transaction start. `lock_set` wins over `lock_clr` in the same cycle.
- R7: After `breq_n` returns to 1 while disconnected, `back_n` returns to 1 on the third rising edge: two synchroniser flops plus the acknowledge register. In that same cycle `disc` and `stall` fall and `ctrl_oe` returns to all ones.
- R8: A transaction whose `txn_start` and `txn_done` are both 1 in the same cycle grants the bus on that edge if the request is present and the lock is clear.
- R9: After `lock_clr`, a request that is still present is granted at the end of the next transaction it is seen at the start of.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| breq_n | input | 1 | Asynchronous wired-OR bus request, active low |
| txn_start | input | 1 | One-cycle pulse: CPU begins a bus transaction |
| txn_done | input | 1 | One-cycle pulse: current transaction completes |
| lock_set | input | 1 | Strobe that sets the bus lock |
| lock_clr | input | 1 | Strobe that clears the bus lock |
| back_n | output | 1 | Bus acknowledge, active low, registered |
| disc | output | 1 | High while the CPU is off the bus |
| stall | output | 1 | Holds off new transactions in the core while disconnected |
| ctrl_oe | output | CTRL_W | Output enables of the control-signal group, 1 = driven |

## Verification
The request is placed in four different positions relative to the transaction framing: several cycles before the start, on the start cycle itself, after the start, and around a transaction that starts and ends in one cycle. The first position shows that the grant waits for done. The second shows the synchroniser latency. The third shows that sampling happens only at the start. The fourth shows the same-edge grant path. A lock pattern sets the lock, presents a request, then clears the lock. This separates refusal from loss of the pending request. Each grant is followed by a release with cycle-exact checks two and three edges after the request rises, which pins down the depth of the release path and shows that the enables are restored together with the acknowledge.

// File: rtl/busrel_pkg.sv
package busrel_pkg;

    typedef enum logic [1:0] {
        BR_IDLE = 2'd0,
        BR_XFER = 2'd1,
        BR_DISC = 2'd2
    } br_state_e;

    typedef struct packed {
        logic start;
        logic done;
    } br_frame_t;

    // grant is allowed only when a request was captured and the lock is clear
    function automatic logic br_may_grant(input logic seen, input logic locked);
        return seen & ~locked;
    endfunction

endpackage

// File: rtl/busrel_sync.sv
module busrel_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_n,
    output logic req
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain <= 1'b1;
                else     chain <= async_n;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain <= '1;
                else     chain <= {chain[STAGES-2:0], async_n};
            end
        end
    endgenerate

    assign req = ~chain[STAGES-1];
endmodule

// File: rtl/busrel_lock.sv
module busrel_lock (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic lock_q
);
    always_ff @(posedge clk) begin
        if (rst)        lock_q <= 1'b0;
        else if (set_i) lock_q <= 1'b1;
        else if (clr_i) lock_q <= 1'b0;
    end
endmodule

// File: rtl/busrel_fsm.sv
module busrel_fsm
    import busrel_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      req,
    input  logic      locked,
    input  br_frame_t frame,
    output logic      ack_n,
    output logic      off_bus
);
    br_state_e state;
    logic      seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= BR_IDLE;
            seen  <= 1'b0;
            ack_n <= 1'b1;
        end else begin
            unique case (state)
                BR_IDLE: begin
                    if (frame.start) begin
                        if (frame.done) begin
                            if (br_may_grant(req, locked)) begin
                                state <= BR_DISC;
                                ack_n <= 1'b0;
                            end
                        end else begin
                            state <= BR_XFER;
                            seen  <= req & ~locked;
                        end
                    end
                end
                BR_XFER: begin
                    if (frame.done) begin
                        seen <= 1'b0;
                        if (br_may_grant(seen, locked)) begin
                            state <= BR_DISC;
                            ack_n <= 1'b0;
                        end else begin
                            state <= BR_IDLE;
                        end
                    end
                end
                BR_DISC: begin
                    if (!req) begin
                        state <= BR_IDLE;
                        ack_n <= 1'b1;
                    end
                end
                default: begin
                    state <= BR_IDLE;
                    ack_n <= 1'b1;
                end
            endcase
        end
    end

    assign off_bus = (state == BR_DISC);
endmodule

// File: rtl/busrel_top.sv
module busrel_top
    import busrel_pkg::*;
#(
    parameter int CTRL_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              breq_n,
    input  logic              txn_start,
    input  logic              txn_done,
    input  logic              lock_set,
    input  logic              lock_clr,
    output logic              back_n,
    output logic              disc,
    output logic              stall,
    output logic [CTRL_W-1:0] ctrl_oe
);
    logic      req_sync;
    logic      lock_q;
    logic      off_bus;
    br_frame_t frame;

    assign frame.start = txn_start;
    assign frame.done  = txn_done;

    busrel_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_n (breq_n),
        .req     (req_sync)
    );

    busrel_lock u_lock (
        .clk    (clk),
        .rst    (rst),
        .set_i  (lock_set),
        .clr_i  (lock_clr),
        .lock_q (lock_q)
    );

    busrel_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .req     (req_sync),
        .locked  (lock_q),
        .frame   (frame),
        .ack_n   (back_n),
        .off_bus (off_bus)
    );

    assign disc    = off_bus;
    assign stall   = off_bus;
    assign ctrl_oe = {CTRL_W{~off_bus}};
endmodule

// File: rtl/busrel_checker.sv
module busrel_checker #(
    parameter int CTRL_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              txn_done,
    input logic              req_sync,
    input logic              lock_q,
    input logic              back_n,
    input logic              disc,
    input logic              stall,
    input logic [CTRL_W-1:0] ctrl_oe
);
    assert_float_when_granted_R5: assert property (@(posedge clk) disable iff (rst)
        !back_n |-> (disc && stall && ctrl_oe == '0));

    assert_driven_when_owned_R5: assert property (@(posedge clk) disable iff (rst)
        back_n |-> (ctrl_oe == '1 && !disc));

    assert_grant_after_done_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(back_n) |-> $past(txn_done));

    assert_no_grant_locked_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(back_n) |-> !$past(lock_q));

    assert_release_needs_idle_req_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(back_n) |-> !$past(req_sync));

    assert_hold_while_requested_R7: assert property (@(posedge clk) disable iff (rst)
        (!back_n && req_sync) |=> !back_n);
endmodule

bind busrel_top busrel_checker #(.CTRL_W(CTRL_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .txn_done (txn_done),
    .req_sync (req_sync),
    .lock_q   (lock_q),
    .back_n   (back_n),
    .disc     (disc),
    .stall    (stall),
    .ctrl_oe  (ctrl_oe)
);

// File: tb/busrel_top_tb_top.sv
module busrel_top_tb_top;
    localparam int CTRL_W = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic breq_n = 1'b1, txn_start = 1'b0, txn_done = 1'b0;
    logic lock_set = 1'b0, lock_clr = 1'b0;
    logic back_n, disc, stall;
    logic [CTRL_W-1:0] ctrl_oe;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    busrel_top #(.CTRL_W(CTRL_W), .SYNC_STAGES(2)) dut_i (
        .clk(clk), .rst(rst), .breq_n(breq_n), .txn_start(txn_start),
        .txn_done(txn_done), .lock_set(lock_set), .lock_clr(lock_clr),
        .back_n(back_n), .disc(disc), .stall(stall), .ctrl_oe(ctrl_oe)
    );

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic check_owned(input string tag);
        check({tag, " back_n"}, {31'd0, back_n}, 32'd1);
        check({tag, " disc"}, {31'd0, disc}, 32'd0);
        check({tag, " stall"}, {31'd0, stall}, 32'd0);
        check({tag, " ctrl_oe"}, {24'd0, ctrl_oe}, 32'hff);
    endtask

    task automatic check_granted(input string tag);
        check({tag, " back_n"}, {31'd0, back_n}, 32'd0);
        check({tag, " disc"}, {31'd0, disc}, 32'd1);
        check({tag, " stall"}, {31'd0, stall}, 32'd1);
        check({tag, " ctrl_oe"}, {24'd0, ctrl_oe}, 32'h00);
    endtask

    task automatic pulse_start();
        txn_start = 1'b1; step(1); txn_start = 1'b0;
    endtask

    task automatic pulse_done();
        txn_done = 1'b1; step(1); txn_done = 1'b0;
    endtask

    // R7: release latency of three edges, enables return together with ack
    task automatic release_bus(input string tag);
        breq_n = 1'b1;
        step(2);
        check_granted({tag, " R7 still held"});
        step(1);
        check_owned({tag, " R7 released"});
    endtask

    task automatic t_reset();
        check_owned("R1 reset");
    endtask

    task automatic t_no_request();
        pulse_start(); step(2); pulse_done(); step(1);
        check_owned("R3 no request");
    endtask

    task automatic t_basic_grant();
        breq_n = 1'b0; step(3);
        pulse_start(); step(2);
        check_owned("R4 before done");
        pulse_done();
        check_granted("R4 R5 after done");
        step(3);
        check_granted("R5 hold while requested");
        release_bus("basic");
    endtask

    task automatic t_sync_latency();
        breq_n = 1'b0;
        pulse_start(); step(2); pulse_done();
        check_owned("R2 request unseen at start");
        pulse_start(); step(1); pulse_done();
        check_granted("R2 seen next transaction");
        release_bus("sync");
    endtask

    task automatic t_mid_request();
        pulse_start();
        breq_n = 1'b0; step(3);
        pulse_done();
        check_owned("R3 mid-transaction request");
        pulse_start(); pulse_done();
        check_granted("R3 next start honoured");
        release_bus("mid");
    endtask

    task automatic t_lock();
        lock_set = 1'b1; lock_clr = 1'b1; step(1);
        lock_set = 1'b0; lock_clr = 1'b0;
        breq_n = 1'b0; step(3);
        pulse_start(); step(1); pulse_done();
        check_owned("R6 locked no grant");
        txn_start = 1'b1; txn_done = 1'b1; step(1);
        txn_start = 1'b0; txn_done = 1'b0;
        check_owned("R6 locked single-cycle");
        lock_clr = 1'b1; step(1); lock_clr = 1'b0;
        check_owned("R9 no grant on clear alone");
        pulse_start(); step(1); pulse_done();
        check_granted("R9 grant after clear");
        release_bus("lock");
    endtask

    task automatic t_single_cycle();
        breq_n = 1'b0; step(3);
        txn_start = 1'b1; txn_done = 1'b1; step(1);
        txn_start = 1'b0; txn_done = 1'b0;
        check_granted("R8 single-cycle grant");
        release_bus("single");
    endtask

    initial begin
        #400000;
        bad++;
        total++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        step(3);
        rst = 1'b0;
        step(1);
        t_reset();
        t_no_request();
        t_basic_grant();
        t_sync_latency();
        t_mid_request();
        t_lock();
        t_single_cycle();
        step(2);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule